// File: doc/BRIEF.md
# Power-Management Clock Rate Divider

This block turns a free-running oscillator into the machine-cycle timing of a small processor core. A two-bit rate field selects one of three ratios: a normal ratio of four oscillator clocks per machine cycle, and two low-power ratios of 64 and 1024 clocks per machine cycle. Every machine cycle is cut into four equal phases, C1 to C4. The block marks the start of each phase with a one-clock strobe and marks the last clock of C4 with a machine-cycle strobe.

Software changes the ratio by writing the rate field. Not every change is allowed. A jump from one low-power ratio straight to the other is refused, and so is the unused code 00. In both cases the field keeps its old value. A hardware switchback pulse pulls a low-power ratio back to the normal ratio. A new ratio only takes hold at a machine-cycle boundary, so a phase is never cut short.

Three timer tick enables are also produced. Each one fires either once per machine cycle or once every three machine cycles (twelve phase-clocks), set by a per-timer select bit. Because all ticks follow the machine cycle, they slow down in step with the low-power ratios.

Top module: `pmd_clk_div`

## Requirements
- R1: Rate code 01 gives machine cycles of 4 oscillator clocks, code 10 gives 64 and code 11 gives 1024. The code read back on `rate_q` is 01 after reset.
- R2: Each machine cycle has four phases of equal length. `ph_stb[k]` is high only on the first clock of phase k+1 (bit 0 is C1, bit 3 is C4), and `mc_stb` is high only on the last clock of C4.
- R3: A write that moves between 01 and 10 or 11, or that rewrites the current code, is accepted. A write that moves directly between 10 and 11 is ignored, and `rate_q` keeps its value.
- R4: A write of code 00 is ignored at any time.
- R5: An accepted write shows on `rate_q` from the clock after the write. The machine cycle in progress still completes at the old length, and the new length applies from the next machine cycle.
- R6: A one-clock `swb_pulse` while `rate_q` is 10 or 11 leaves `rate_q` unchanged until the end of the current machine cycle. At that boundary `rate_q` becomes 01, and the next machine cycle lasts 4 clocks.
- R7: A `swb_pulse` while `rate_q` is 01 has no effect on `rate_q` or on machine-cycle length.
- R8: Timer select bits reset to 0. With bit i at 0, `tmr_tick[i]` pulses together with every third `mc_stb` counted from reset (the 3rd, the 6th, and so on). With bit i at 1, it pulses with every `mc_stb`. A write on `tsel_we` loads all select bits, and bit i belongs to timer i.
- R9: A timer tick is never high on a clock where `mc_stb` is low, so tick rates scale with the selected ratio.
- R10: While `rst_n` is low, `rate_q` reads 01, `mc_stb` and every `tmr_tick` bit are 0, and `ph_stb` reads 0001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rate_we | input | 1 | Write strobe for the rate field |
| rate_wdata | input | 2 | Requested rate code |
| swb_pulse | input | 1 | Hardware switchback request, one clock wide |
| tsel_we | input | 1 | Write strobe for the timer select bits |
| tsel_wdata | input | 3 | Timer select bits, 1 = once per machine cycle |
| rate_q | output | 2 | Current rate field |
| mc_stb | output | 1 | Last clock of each machine cycle |
| ph_stb | output | 4 | Phase-start strobes, C1 in bit 0 |
| tmr_tick | output | 3 | Per-timer tick enables |

## Verification
The rate field is driven through a sequence of writes that covers every kind of change. Some writes are legal (normal to each low-power ratio and back). Some are refused (the hop between the two low-power ratios, and code 00). A write placed in the middle of a cycle shows whether a change lands at the boundary or too early. Switchback pulses are sent in both low-power ratios and in the normal ratio, which separates a correctly deferred return from an immediate one and from a spurious one. The scoreboard measures every machine cycle's length and phase layout and compares it with the expected ratio. Timer ticks are checked with the select bits both cleared and mixed, which exposes a wrong modulo-three count or a swapped timer bit.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

  typedef enum logic [1:0] {
    RT_OFF  = 2'b00,
    RT_NORM = 2'b01,
    RT_LP1  = 2'b10,
    RT_LP2  = 2'b11
  } rate_t;

  // A request is accepted unless it is the unused code or a hop between
  // the two low-power codes.
  function automatic logic rate_legal(input rate_t cur, input logic [1:0] req);
    logic hop;
    hop = cur[1] && req[1] && (cur != rate_t'(req));
    return (req != 2'b00) && !hop;
  endfunction

endpackage

// File: rtl/pmd_rate_ctl.sv
module pmd_rate_ctl
  import pmd_pkg::*;
#(
  parameter int N_PH     = 4,
  parameter int NORM_DIV = 4,
  parameter int LP1_DIV  = 64,
  parameter int LP2_DIV  = 1024,
  parameter int PRE_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_data,
  input  logic             swb,
  input  logic             mc_end,
  output rate_t            field_q,
  output logic [PRE_W-1:0] pre_max
);

  localparam int PL_NORM = NORM_DIV / N_PH - 1;
  localparam int PL_LP1  = LP1_DIV / N_PH - 1;
  localparam int PL_LP2  = LP2_DIV / N_PH - 1;

  rate_t act_q, act_d, field_d;
  logic  pend_q, pend_d;
  logic  wr_ok, swb_set, force_norm;

  always_comb begin
    wr_ok      = wr_en && rate_legal(field_q, wr_data);
    swb_set    = swb && (field_q != RT_NORM);
    force_norm = mc_end && (pend_q || swb_set);

    if (force_norm)      field_d = RT_NORM;
    else if (wr_ok)      field_d = rate_t'(wr_data);
    else                 field_d = field_q;

    act_d  = mc_end ? field_d : act_q;
    pend_d = mc_end ? 1'b0 : (pend_q || swb_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= RT_NORM;
      act_q   <= RT_NORM;
      pend_q  <= 1'b0;
    end else begin
      field_q <= field_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    case (act_q)
      RT_LP1:  pre_max = PRE_W'(PL_LP1);
      RT_LP2:  pre_max = PRE_W'(PL_LP2);
      default: pre_max = PRE_W'(PL_NORM);
    endcase
  end

endmodule

// File: rtl/pmd_phase_gen.sv
module pmd_phase_gen #(
  parameter int N_PH  = 4,
  parameter int PRE_W = 8,
  localparam int PH_W = (N_PH > 1) ? $clog2(N_PH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] pre_max,
  output logic [N_PH-1:0]  ph_stb,
  output logic             mc_end
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic             pre_end, ph_last;

  always_comb begin
    pre_end = (pre_q == pre_max);
    ph_last = (ph_q == PH_W'(N_PH - 1));
    mc_end  = pre_end && ph_last;

    if (pre_end) begin
      pre_d = '0;
      ph_d  = ph_last ? '0 : ph_q + PH_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
      ph_d  = ph_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end

  for (genvar k = 0; k < N_PH; k++) begin : g_ph
    assign ph_stb[k] = (pre_q == '0) && (ph_q == PH_W'(k));
  end

endmodule

// File: rtl/pmd_tick_gen.sv
module pmd_tick_gen #(
  parameter int N_TMR   = 3,
  parameter int SLOW_MC = 3,
  localparam int MC_W   = (SLOW_MC > 1) ? $clog2(SLOW_MC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_end,
  input  logic             tsel_we,
  input  logic [N_TMR-1:0] tsel_wdata,
  output logic [N_TMR-1:0] tick
);

  logic [N_TMR-1:0] tsel_q, tsel_d;
  logic [MC_W-1:0]  mc_q, mc_d;
  logic             slow_hit;

  always_comb begin
    slow_hit = (mc_q == MC_W'(SLOW_MC - 1));
    tsel_d   = tsel_we ? tsel_wdata : tsel_q;
    if (mc_end) mc_d = slow_hit ? '0 : mc_q + MC_W'(1);
    else        mc_d = mc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q <= '0;
      mc_q   <= '0;
    end else begin
      tsel_q <= tsel_d;
      mc_q   <= mc_d;
    end
  end

  for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
    assign tick[i] = mc_end && (tsel_q[i] || slow_hit);
  end

endmodule

// File: rtl/pmd_clk_div.sv
module pmd_clk_div
  import pmd_pkg::*;
#(
  parameter int N_TMR    = 3,
  parameter int N_PH     = 4,
  parameter int NORM_DIV = 4,
  parameter int LP1_DIV  = 64,
  parameter int LP2_DIV  = 1024,
  parameter int SLOW_MC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rate_we,
  input  logic [1:0]       rate_wdata,
  input  logic             swb_pulse,
  input  logic             tsel_we,
  input  logic [N_TMR-1:0] tsel_wdata,
  output logic [1:0]       rate_q,
  output logic             mc_stb,
  output logic [N_PH-1:0]  ph_stb,
  output logic [N_TMR-1:0] tmr_tick
);

  localparam int MAX_PL = LP2_DIV / N_PH;
  localparam int PRE_W  = (MAX_PL > 1) ? $clog2(MAX_PL) : 1;

  logic [1:0]       rs_q;
  logic             rst_i_n;
  rate_t            field;
  logic [PRE_W-1:0] pre_max;
  logic             mc_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  pmd_rate_ctl #(
    .N_PH(N_PH), .NORM_DIV(NORM_DIV), .LP1_DIV(LP1_DIV),
    .LP2_DIV(LP2_DIV), .PRE_W(PRE_W)
  ) u_rate (
    .clk(clk), .rst_n(rst_i_n), .wr_en(rate_we), .wr_data(rate_wdata),
    .swb(swb_pulse), .mc_end(mc_end), .field_q(field), .pre_max(pre_max)
  );

  pmd_phase_gen #(.N_PH(N_PH), .PRE_W(PRE_W)) u_phase (
    .clk(clk), .rst_n(rst_i_n), .pre_max(pre_max),
    .ph_stb(ph_stb), .mc_end(mc_end)
  );

  pmd_tick_gen #(.N_TMR(N_TMR), .SLOW_MC(SLOW_MC)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .mc_end(mc_end),
    .tsel_we(tsel_we), .tsel_wdata(tsel_wdata), .tick(tmr_tick)
  );

  assign rate_q = field;
  assign mc_stb = mc_end;

endmodule

// File: rtl/pmd_clk_div_chk.sv
module pmd_clk_div_chk #(
  parameter int N_PH  = 4,
  parameter int N_TMR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rate_we,
  input logic             swb_pulse,
  input logic [1:0]       rate_q,
  input logic             mc_stb,
  input logic [N_PH-1:0]  ph_stb,
  input logic [N_TMR-1:0] tmr_tick
);

  // R4
  rate_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q != 2'b00);

  // R3
  no_lp_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q[1] && $past(rate_q[1])) |-> (rate_q == $past(rate_q)));

  // R2
  ph_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ph_stb));

  // R2
  mc_then_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stb |=> ph_stb[0]);

  // R9
  tick_on_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tmr_tick) |-> mc_stb);

  // R7
  swb_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 2'b01 && swb_pulse && !rate_we) |=> (rate_q == 2'b01));

endmodule

bind pmd_clk_div pmd_clk_div_chk #(.N_PH(N_PH), .N_TMR(N_TMR)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .swb_pulse(swb_pulse),
  .rate_q(rate_q), .mc_stb(mc_stb), .ph_stb(ph_stb), .tmr_tick(tmr_tick)
);

// File: tb/sim_pmd_clk_div.sv
`timescale 1ns/1ps
module sim_pmd_clk_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate_we = 1'b0;
  logic [1:0] rate_wdata = 2'b00;
  logic       swb_pulse = 1'b0;
  logic       tsel_we = 1'b0;
  logic [2:0] tsel_wdata = 3'b000;
  logic [1:0] rate_q;
  logic       mc_stb;
  logic [3:0] ph_stb;
  logic [2:0] tmr_tick;

  always #10 clk = ~clk;

  pmd_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .rate_we(rate_we), .rate_wdata(rate_wdata),
    .swb_pulse(swb_pulse), .tsel_we(tsel_we), .tsel_wdata(tsel_wdata),
    .rate_q(rate_q), .mc_stb(mc_stb), .ph_stb(ph_stb), .tmr_tick(tmr_tick)
  );

  int   nvec = 0;
  int   nbad = 0;
  int   expq[$];
  logic [1:0] exp_field = 2'b01;
  logic [2:0] exp_tsel = 3'b000;
  bit   pend = 0;
  int   cur_len = 4;
  bit   run = 0;
  bit   done = 0;

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int len_of(input logic [1:0] c);
    case (c)
      2'b10:   return 64;
      2'b11:   return 1024;
      default: return 4;
    endcase
  endfunction

  // Monitor: measures each machine cycle, its phase layout and its ticks
  int  cnt = 0;
  int  mcn = 0;
  bit  seen = 0;
  bit  perr = 0;
  always @(negedge clk) begin
    if (run) begin
      if (seen && expq.size() > 0) begin
        int plen, pos;
        logic [3:0] eph;
        plen = expq[0] / 4;
        pos  = cnt;
        eph  = (pos % plen == 0 && pos / plen < 4) ? (4'b0001 << (pos / plen)) : 4'b0000;
        if (ph_stb !== eph) perr = 1;
        if (!mc_stb && tmr_tick != 3'b000) perr = 1;
      end
      if (mc_stb) begin
        logic [2:0] etk;
        etk = exp_tsel | ((mcn % 3 == 2) ? 3'b111 : 3'b000);
        chk("R8 tick pattern at boundary", int'(tmr_tick), int'(etk));
        if (seen) begin
          if (expq.size() == 0) chk("R1 scoreboard empty", 1, 0);
          else begin
            int e;
            e = expq.pop_front();
            chk("R1 machine cycle length", cnt + 1, e);
            chk("R2/R9 phase layout and tick placement", int'(perr), 0);
          end
        end
        mcn++;
        cnt  = 0;
        perr = 0;
        seen = 1;
      end else begin
        cnt++;
      end
    end
  end

  // Driver: one call per machine cycle; op 0 idle, 1 rate write, 2 switchback, 3 timer select
  task automatic mcyc(input int op, input logic [2:0] d, input string tag);
    expq.push_back(cur_len);
    @(negedge clk);
    chk({tag, " rate readback"}, int'(rate_q), int'(exp_field));
    if (op == 1) begin
      bit legal;
      rate_we = 1'b1; rate_wdata = d[1:0];
      @(negedge clk);
      rate_we = 1'b0;
      legal = (d[1:0] != 2'b00) && !(exp_field[1] && d[1] && exp_field != d[1:0]);
      if (legal) exp_field = d[1:0];
      chk({tag, " field after write"}, int'(rate_q), int'(exp_field));
    end else if (op == 2) begin
      swb_pulse = 1'b1;
      @(negedge clk);
      swb_pulse = 1'b0;
      if (exp_field != 2'b01) pend = 1;
      chk({tag, " field held until boundary"}, int'(rate_q), int'(exp_field));
    end else if (op == 3) begin
      tsel_we = 1'b1; tsel_wdata = d;
      @(negedge clk);
      tsel_we = 1'b0;
      exp_tsel = d;
    end
    do @(negedge clk); while (!mc_stb);
    #1;
    if (pend) begin
      exp_field = 2'b01;
      pend = 0;
    end
    cur_len = len_of(exp_field);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rate_q in reset", int'(rate_q), 1);
    chk("R10 mc_stb in reset", int'(mc_stb), 0);
    chk("R10 tmr_tick in reset", int'(tmr_tick), 0);
    chk("R10 ph_stb in reset", int'(ph_stb), 1);
    rst_n = 1'b1;
    run = 1;
    do @(negedge clk); while (!mc_stb);
    #1;
    repeat (3) mcyc(0, 3'd0, "R1");
    mcyc(1, 3'd0, "R4");
    mcyc(1, 3'd2, "R3");
    mcyc(0, 3'd0, "R5");
    mcyc(0, 3'd0, "R5");
    mcyc(1, 3'd3, "R3");
    mcyc(2, 3'd0, "R6");
    mcyc(0, 3'd0, "R6");
    mcyc(3, 3'b101, "R8");
    repeat (4) mcyc(0, 3'd0, "R8");
    mcyc(2, 3'd0, "R7");
    mcyc(0, 3'd0, "R7");
    mcyc(1, 3'd3, "R3");
    mcyc(0, 3'd0, "R9");
    mcyc(1, 3'd2, "R3");
    mcyc(1, 3'd1, "R3");
    mcyc(0, 3'd0, "R5");
    mcyc(1, 3'd0, "R4");
    mcyc(1, 3'd3, "R3");
    mcyc(2, 3'd0, "R6");
    mcyc(0, 3'd0, "R6");
    mcyc(1, 3'd1, "R3");
    mcyc(0, 3'd0, "R1");
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule